// File: doc/BRIEF.md
# ADC Sampling Sequencer

This block sequences a multi-channel converter that is shared between channels (two channels by default). When enabled it releases the converter's power-down and waits a programmable warm-up time. It then selects the channels one at a time, lowest index first. Each selection is held until the converter reports a finished conversion, and the returned value is stored in that channel's sample register. A mode input picks one of three behaviours. One-shot mode takes a single round and then stops with a sticky done flag. Continuous mode repeats rounds back to back with the converter left powered. Low-power mode takes one round and then powers the converter down for a programmable rest interval, repeating the warm-up before every round.

In low-power mode an external comparison supplies a match indication for each round. Once a programmable number of consecutive matching rounds has been seen, the block leaves low-power operation, pulses a wake request and continues in continuous mode. A miss restarts the count. Everything runs on a single always-on clock, so the low-power loop and the wake request do not depend on any faster clock. Dropping the enable, or pulsing the software sequencer reset, returns the block to idle at once and clears its timers and match progress.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After power-down deasserts, no channel is selected for exactly pwrup_cnt_i+1 clock cycles. Channel 0 is then selected.
- R2: At most one bit of adc_chn_sel_o is high in any cycle. Within a round, channel 0 comes before channel 1. A selection is held until adc_valid_i is sampled high while it is active.
- R3: When adc_valid_i is high while channel k is selected, samples_o[k*DATA_W +: DATA_W] holds adc_data_i from the next cycle on. adc_valid_i has no effect while no channel is selected.
- R4: mode_i=0 is one-shot. After the last channel's valid, power-down is asserted, no channel is selected and the block stays halted while enable_i remains high.
- R5: oneshot_done_o goes high the cycle after a one-shot round completes and stays high until done_clr_i is sampled high. A set in the same cycle as a clear wins.
- R6: mode_i=1 or 3 is continuous. After the last channel's valid, channel 0 is selected in the next cycle and power-down stays low.
- R7: mode_i=2 is low-power. lp_mode_o is high. After each non-exiting round, power-down stays high for exactly wake_cnt_i+1 cycles, and the R1 warm-up then repeats.
- R8: In low-power mode, match_i is sampled with the last channel's valid. A miss resets the count of consecutive matches. When the count reaches match_goal_i (0 is treated as 1), lp_mode_o falls, wake_o pulses for one cycle and sampling continues as in R6.
- R9: A cycle with fsm_rst_i high puts the block in idle in the next cycle: power-down high, no channel selected, lp_mode_o low, match count cleared. oneshot_done_o and the samples are kept. If enable_i is high, the block starts over after fsm_rst_i falls.
- R10: After reset, and in the cycle after enable_i is sampled low, power-down is high, no channel is selected and lp_mode_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Run enable; low forces idle |
| fsm_rst_i | input | 1 | Synchronous software reset of sequencer and counters |
| mode_i | input | 2 | 0 one-shot, 1/3 continuous, 2 low-power; taken at start |
| pwrup_cnt_i | input | PWR_W | Warm-up wait after power-up (cycles minus one) |
| wake_cnt_i | input | WAKE_W | Low-power rest interval (cycles minus one) |
| match_goal_i | input | MATCH_W | Consecutive matching rounds needed to leave low-power |
| match_i | input | 1 | Match result of the current round |
| adc_data_i | input | DATA_W | Converter result |
| adc_valid_i | input | 1 | Converter result valid |
| done_clr_i | input | 1 | Write-one-to-clear of the done flag |
| adc_pd_o | output | 1 | Converter power-down |
| adc_chn_sel_o | output | NCH | One-hot channel select |
| samples_o | output | NCH*DATA_W | Captured samples, channel k at bits k*DATA_W |
| oneshot_done_o | output | 1 | Sticky one-shot completion flag |
| lp_mode_o | output | 1 | High while sampling in low-power mode |
| wake_o | output | 1 | One-cycle wake request on leaving low-power |

## Verification
All outputs come from registers. A change on an input shows at the outputs one clock edge later. The only exceptions are the programmed waits: a selection arrives pwrup_cnt_i+1 edges after power-down falls, and a rest lasts wake_cnt_i+1 edges. The bench drives inputs and samples outputs on the falling edge. Its reference model advances on the same rising edge as the design, so each expected value is compared half a cycle after the edge that produces it. The directed checks count falling edges between observed output transitions and compare the counts against the programmed values. The wake check compares the round count at the wake pulse with the round the match pattern predicts.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_WARM = 3'd1,
      ST_CONV = 3'd2,
      ST_REST = 3'd3,
      ST_HALT = 3'd4
   } seq_state_e;

   typedef enum logic [1:0] {
      MODE_ONESHOT = 2'd0,
      MODE_CONT    = 2'd1,
      MODE_LOWPWR  = 2'd2,
      MODE_CONT_B  = 2'd3
   } seq_mode_e;

endpackage

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
   parameter int unsigned W = 12
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         clr_i,
   input  logic         load_i,
   input  logic [W-1:0] val_i,
   input  logic         dec_i,
   output logic         zero_o
);

   if (W < 1) begin : g_chk_w
      $error("timer width must be at least 1");
   end

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     cnt_q <= '0;
      else if (clr_i)  cnt_q <= '0;
      else if (load_i) cnt_q <= val_i;
      else if (dec_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
   end

   assign zero_o = (cnt_q == '0);

   // R1 / R7: a load sets the wait length used by the sequencer
   p_load_value_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (load_i && !clr_i) |=> (cnt_q == $past(val_i)));

   // R9: the software reset clears the timer
   p_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i |=> zero_o);

endmodule

// File: rtl/adc_seq_hits.sv
module adc_seq_hits #(
   parameter int unsigned W = 6
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         clr_i,
   input  logic         step_i,
   input  logic         hit_i,
   input  logic [W-1:0] goal_i,
   output logic         reached_o
);

   if (W < 1) begin : g_chk_w
      $error("match counter width must be at least 1");
   end

   logic [W-1:0] cnt_q;
   logic [W:0]   next_w;
   logic [W:0]   goal_eff;

   assign next_w    = {1'b0, cnt_q} + 1'b1;
   assign goal_eff  = (goal_i == '0) ? (W+1)'(1) : {1'b0, goal_i};
   assign reached_o = step_i && hit_i && (next_w >= goal_eff);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    cnt_q <= '0;
      else if (clr_i) cnt_q <= '0;
      else if (step_i) begin
         if (!hit_i || reached_o) cnt_q <= '0;
         else                     cnt_q <= next_w[W-1:0];
      end
   end

   // R8: a miss restarts the consecutive count
   p_miss_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (step_i && !hit_i && !clr_i) |=> (cnt_q == '0));

   // R8: the count only moves on an evaluated round
   p_count_holds_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!step_i && !clr_i) |=> $stable(cnt_q));

endmodule

// File: rtl/adc_seq_capture.sv
module adc_seq_capture #(
   parameter int unsigned NCH    = 2,
   parameter int unsigned DATA_W = 10,
   parameter int unsigned CW     = 1
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic                  cap_en_i,
   input  logic [CW-1:0]         cap_idx_i,
   input  logic [DATA_W-1:0]     data_i,
   output logic [NCH*DATA_W-1:0] smp_o
);

   if ((1 << CW) < NCH) begin : g_chk_cw
      $error("index width too small for channel count");
   end

   for (genvar g = 0; g < NCH; g++) begin : g_ch
      logic [DATA_W-1:0] smp_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) smp_q <= '0;
         else if (cap_en_i && cap_idx_i == CW'(g)) smp_q <= data_i;
      end
      assign smp_o[g*DATA_W +: DATA_W] = smp_q;
   end

   // R3: without a capture strobe every sample register holds
   p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cap_en_i |=> $stable(smp_o));

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
   import adc_seq_pkg::*;
#(
   parameter int unsigned NCH     = 2,
   parameter int unsigned DATA_W  = 10,
   parameter int unsigned PWR_W   = 8,
   parameter int unsigned WAKE_W  = 12,
   parameter int unsigned MATCH_W = 6
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic                  enable_i,
   input  logic                  fsm_rst_i,
   input  logic [1:0]            mode_i,
   input  logic [PWR_W-1:0]      pwrup_cnt_i,
   input  logic [WAKE_W-1:0]     wake_cnt_i,
   input  logic [MATCH_W-1:0]    match_goal_i,
   input  logic                  match_i,
   input  logic [DATA_W-1:0]     adc_data_i,
   input  logic                  adc_valid_i,
   input  logic                  done_clr_i,
   output logic                  adc_pd_o,
   output logic [NCH-1:0]        adc_chn_sel_o,
   output logic [NCH*DATA_W-1:0] samples_o,
   output logic                  oneshot_done_o,
   output logic                  lp_mode_o,
   output logic                  wake_o
);

   localparam int unsigned CW = (NCH > 1) ? $clog2(NCH) : 1;
   localparam int unsigned TW = (PWR_W > WAKE_W) ? PWR_W : WAKE_W;

   if (NCH < 2) begin : g_chk_nch
      $error("at least two channels are required");
   end
   if (DATA_W < 1) begin : g_chk_dw
      $error("sample width must be at least 1");
   end
   if (PWR_W < 1 || WAKE_W < 1 || MATCH_W < 1) begin : g_chk_cnt
      $error("counter widths must be at least 1");
   end

   seq_state_e    st_q, st_d;
   seq_mode_e     mode_q, mode_d;
   logic [CW-1:0] ch_q, ch_d;
   logic          lp_q, lp_d;
   logic          wake_q, done_q, done_d;

   logic          abort, last_ch, smp_ev, round_end;
   logic          hit_step, reached;
   logic          tmr_load, tmr_dec, tmr_zero;
   logic [TW-1:0] tmr_val;

   assign abort     = fsm_rst_i || !enable_i;
   assign last_ch   = (ch_q == CW'(NCH-1));
   assign smp_ev    = (st_q == ST_CONV) && adc_valid_i;
   assign round_end = smp_ev && last_ch;
   assign hit_step  = round_end && lp_q && !abort;

   adc_seq_timer #(.W(TW)) u_timer (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (abort),
      .load_i (tmr_load),
      .val_i  (tmr_val),
      .dec_i  (tmr_dec),
      .zero_o (tmr_zero)
   );

   adc_seq_hits #(.W(MATCH_W)) u_hits (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .clr_i     (abort),
      .step_i    (hit_step),
      .hit_i     (match_i),
      .goal_i    (match_goal_i),
      .reached_o (reached)
   );

   adc_seq_capture #(.NCH(NCH), .DATA_W(DATA_W), .CW(CW)) u_capture (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .cap_en_i  (smp_ev && !abort),
      .cap_idx_i (ch_q),
      .data_i    (adc_data_i),
      .smp_o     (samples_o)
   );

   always_comb begin
      st_d     = st_q;
      mode_d   = mode_q;
      ch_d     = ch_q;
      lp_d     = lp_q;
      tmr_load = 1'b0;
      tmr_dec  = 1'b0;
      tmr_val  = TW'(pwrup_cnt_i);
      unique case (st_q)
         ST_IDLE: begin
            st_d     = ST_WARM;
            mode_d   = seq_mode_e'(mode_i);
            lp_d     = (seq_mode_e'(mode_i) == MODE_LOWPWR);
            tmr_load = 1'b1;
         end
         ST_WARM: begin
            if (tmr_zero) begin
               st_d = ST_CONV;
               ch_d = '0;
            end else begin
               tmr_dec = 1'b1;
            end
         end
         ST_CONV: begin
            if (smp_ev) begin
               if (!last_ch) begin
                  ch_d = ch_q + 1'b1;
               end else begin
                  ch_d = '0;
                  if (mode_q == MODE_ONESHOT) begin
                     st_d = ST_HALT;
                  end else if (lp_q) begin
                     if (reached) begin
                        lp_d = 1'b0;
                     end else begin
                        st_d     = ST_REST;
                        tmr_load = 1'b1;
                        tmr_val  = TW'(wake_cnt_i);
                     end
                  end
               end
            end
         end
         ST_REST: begin
            if (tmr_zero) begin
               st_d     = ST_WARM;
               tmr_load = 1'b1;
            end else begin
               tmr_dec = 1'b1;
            end
         end
         ST_HALT: ;
         default: st_d = ST_IDLE;
      endcase
      if (abort) begin
         st_d = ST_IDLE;
         ch_d = '0;
         lp_d = 1'b0;
      end
   end

   always_comb begin
      done_d = done_q;
      if (done_clr_i) done_d = 1'b0;
      if (round_end && mode_q == MODE_ONESHOT && !abort) done_d = 1'b1;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q   <= ST_IDLE;
         mode_q <= MODE_ONESHOT;
         ch_q   <= '0;
         lp_q   <= 1'b0;
         wake_q <= 1'b0;
         done_q <= 1'b0;
      end else begin
         st_q   <= st_d;
         mode_q <= mode_d;
         ch_q   <= ch_d;
         lp_q   <= lp_d;
         wake_q <= reached;
         done_q <= done_d;
      end
   end

   for (genvar g = 0; g < NCH; g++) begin : g_sel
      assign adc_chn_sel_o[g] = (st_q == ST_CONV) && (ch_q == CW'(g));
   end

   assign adc_pd_o       = !(st_q == ST_WARM || st_q == ST_CONV);
   assign oneshot_done_o = done_q;
   assign lp_mode_o      = lp_q;
   assign wake_o         = wake_q;

   // R2: never two channels at once
   p_one_sel_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(adc_chn_sel_o));

   // R1: a selection only begins once the warm-up timer has run out
   p_warm_first_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(|adc_chn_sel_o) |-> $past(st_q == ST_WARM && tmr_zero));

   // R2: a selection is held until the converter answers
   p_sel_held_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q == ST_CONV && !adc_valid_i && !abort) |=> $stable(adc_chn_sel_o));

   // R10 / R9: disable or software reset forces idle outputs
   p_abort_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      abort |=> (adc_pd_o && adc_chn_sel_o == '0 && !lp_mode_o));

   // R5: the done flag only falls on a clear
   p_done_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (oneshot_done_o && !done_clr_i) |=> oneshot_done_o);

   // R8: a wake pulse marks the exit from low-power operation
   p_wake_exit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wake_o |-> (!lp_mode_o && $past(lp_mode_o)));

endmodule

// File: tb/adc_seq_ctrl_test.sv
`timescale 1ns/1ps
module adc_seq_ctrl_test;

   localparam int LIMIT = 150000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        enable = 1'b0, fsm_rst = 1'b0, done_clr = 1'b0;
   logic [1:0]  mode = 2'd0;
   logic [7:0]  pwrup = 8'd0;
   logic [11:0] wakec = 12'd0;
   logic [5:0]  goal = 6'd1;
   logic        match;
   logic [9:0]  adc_data = 10'd0;
   logic        adc_valid = 1'b0;
   logic        pd, done, lp, wake;
   logic [1:0]  sel;
   logic [19:0] samples;

   int errors = 0, checks = 0, cyc = 0;
   int resp_dly = 2, rcnt = 0, dat = 5, rounds = 0, rbase = 0;
   int wake_seen = 0, wake_round = -1;
   bit stray = 1'b0;
   logic [7:0] pat = 8'h00;
   int last_dat [2];

   // reference model state
   int ph = 0, m_ch = 0, m_mode = 0, m_left = 0, m_hits = 0;
   bit m_lp = 0, m_wake = 0, m_done = 0;
   int m_smp [2];

   always #2 clk = ~clk;

   adc_seq_ctrl uut (
      .clk_i(clk), .rst_ni(rst_n), .enable_i(enable), .fsm_rst_i(fsm_rst),
      .mode_i(mode), .pwrup_cnt_i(pwrup), .wake_cnt_i(wakec),
      .match_goal_i(goal), .match_i(match), .adc_data_i(adc_data),
      .adc_valid_i(adc_valid), .done_clr_i(done_clr), .adc_pd_o(pd),
      .adc_chn_sel_o(sel), .samples_o(samples), .oneshot_done_o(done),
      .lp_mode_o(lp), .wake_o(wake)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   assign match = pat[(rounds - rbase) % 8];

   // converter responder
   always @(negedge clk) begin
      if (sel != 2'b00) begin
         if (rcnt >= resp_dly) begin
            dat = (dat * 37 + 11) % 1024;
            adc_data <= 10'(dat);
            adc_valid <= 1'b1;
            last_dat[sel[1] ? 1 : 0] = dat;
            rcnt = 0;
         end else begin
            adc_valid <= 1'b0;
            rcnt++;
         end
      end else begin
         rcnt = 0;
         adc_valid <= stray;
         adc_data <= 10'(dat ^ 341);
      end
   end

   always @(posedge clk) begin
      if (rst_n && adc_valid && sel[1]) rounds++;
   end

   // behavioural reference model
   always @(posedge clk) begin
      if (!rst_n) begin
         ph = 0; m_ch = 0; m_mode = 0; m_hits = 0; m_lp = 0; m_wake = 0;
         m_done = 0; m_smp[0] = 0; m_smp[1] = 0;
      end else begin
         m_wake = 0;
         if (done_clr) m_done = 0;
         if (fsm_rst || !enable) begin
            ph = 0; m_ch = 0; m_hits = 0; m_lp = 0;
         end else begin
            case (ph)
               0: begin
                  m_mode = int'(mode); m_lp = (mode == 2'd2);
                  ph = 1; m_left = int'(pwrup);
               end
               1: if (m_left == 0) begin ph = 2; m_ch = 0; end else m_left--;
               2: if (adc_valid) begin
                  m_smp[m_ch] = int'(adc_data);
                  if (m_ch == 0) m_ch = 1;
                  else begin
                     m_ch = 0;
                     if (m_mode == 0) begin m_done = 1; ph = 4; end
                     else if (m_lp) begin
                        if (match) begin
                           m_hits++;
                           if (m_hits >= ((goal == 0) ? 1 : int'(goal))) begin
                              m_lp = 0; m_wake = 1; m_hits = 0;
                           end
                        end else m_hits = 0;
                        if (m_lp) begin ph = 3; m_left = int'(wakec); end
                     end
                  end
               end
               3: if (m_left == 0) begin ph = 1; m_left = int'(pwrup); end else m_left--;
               default: ;
            endcase
         end
      end
   end

   // compare on every falling edge
   always @(negedge clk) begin
      if (rst_n) begin
         chk("R1 pd", int'(pd), (ph == 1 || ph == 2) ? 0 : 1);
         chk("R2 sel", int'(sel), (ph == 2) ? (1 << m_ch) : 0);
         chk("R3 samples", int'(samples), m_smp[0] + (m_smp[1] << 10));
         chk("R5 done", int'(done), int'(m_done));
         chk("R7 lp", int'(lp), int'(m_lp));
         chk("R8 wake", int'(wake), int'(m_wake));
         if (wake) begin wake_seen++; wake_round = rounds - rbase; end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc == LIMIT) begin
         errors++;
         $display("FAIL R10 watchdog: cycles=%0d expected < %0d", cyc, LIMIT);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   task automatic stop_run();
      @(negedge clk); enable = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic start_run(input logic [1:0] md, input int pw, input int wk, input int gl);
      @(negedge clk);
      mode = md; pwrup = 8'(pw); wakec = 12'(wk); goal = 6'(gl);
      rbase = rounds; enable = 1'b1;
   endtask

   initial begin
      int n, hold;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10 reset pd", int'(pd), 1);
      chk("R10 reset sel", int'(sel), 0);
      chk("R10 reset done", int'(done), 0);
      chk("R10 reset lp", int'(lp), 0);

      // continuous mode, stray valids during warm-up
      resp_dly = 3; stray = 1'b1;
      hold = int'(samples);
      start_run(2'd1, 5, 0, 1);
      for (int i = 0; i < 50 && pd; i++) @(negedge clk);
      n = 0;
      for (int i = 0; i < 300 && sel == 2'b00; i++) begin @(negedge clk); n++; end
      chk("R1 warm-up length", n, 6);
      chk("R3 stray valid ignored", int'(samples), hold);
      stray = 1'b0;
      chk("R2 first channel", int'(sel), 1);
      for (int i = 0; i < 50 && sel == 2'b01; i++) @(negedge clk);
      chk("R2 second channel", int'(sel), 2);
      for (int i = 0; i < 50 && sel == 2'b10; i++) @(negedge clk);
      chk("R6 back to channel 0", int'(sel), 1);
      n = 0;
      for (int i = 0; i < 60; i++) begin @(negedge clk); if (pd) n++; end
      chk("R6 stays powered", n, 0);
      for (int i = 0; i < 50 && sel == 2'b00; i++) @(negedge clk);
      enable = 1'b0;
      @(negedge clk);
      chk("R10 disable pd", int'(pd), 1);
      chk("R10 disable sel", int'(sel), 0);
      @(negedge clk);

      // one-shot
      resp_dly = 1;
      start_run(2'd0, 2, 0, 1);
      for (int i = 0; i < 200 && !done; i++) @(negedge clk);
      chk("R4 done set", int'(done), 1);
      chk("R4 halted pd", int'(pd), 1);
      repeat (20) @(negedge clk);
      chk("R4 still halted pd", int'(pd), 1);
      chk("R4 still halted sel", int'(sel), 0);
      chk("R3 channel 0 sample", int'(samples[9:0]), last_dat[0]);
      chk("R3 channel 1 sample", int'(samples[19:10]), last_dat[1]);
      stop_run();

      // low-power, never matching
      pat = 8'h00;
      start_run(2'd2, 3, 7, 2);
      repeat (2) @(negedge clk);
      chk("R7 lp indicator", int'(lp), 1);
      for (int i = 0; i < 200 && pd; i++) @(negedge clk);
      for (int i = 0; i < 200 && !pd; i++) @(negedge clk);
      n = 0;
      for (int i = 0; i < 200 && pd; i++) begin @(negedge clk); n++; end
      chk("R7 rest length", n, 8);
      n = 0;
      for (int i = 0; i < 200 && sel == 2'b00; i++) begin @(negedge clk); n++; end
      chk("R7 warm-up repeats", n, 4);

      // software reset during rest
      for (int i = 0; i < 200 && !pd; i++) @(negedge clk);
      @(negedge clk);
      fsm_rst = 1'b1;
      @(negedge clk);
      chk("R9 pd after fsm reset", int'(pd), 1);
      chk("R9 sel after fsm reset", int'(sel), 0);
      chk("R9 lp after fsm reset", int'(lp), 0);
      chk("R9 done kept", int'(done), 1);
      fsm_rst = 1'b0;
      repeat (2) @(negedge clk);
      chk("R9 restart", int'(lp), 1);
      stop_run();

      // clear the done flag
      done_clr = 1'b1;
      @(negedge clk);
      done_clr = 1'b0;
      chk("R5 done cleared", int'(done), 0);

      // low-power exit after three consecutive matches
      pat = 8'b1111_1011; wake_seen = 0; wake_round = -1;
      start_run(2'd2, 1, 3, 3);
      for (int i = 0; i < 2000 && wake_seen == 0; i++) @(negedge clk);
      chk("R8 wake after round", wake_round, 6);
      chk("R8 lp cleared", int'(lp), 0);
      n = 0;
      for (int i = 0; i < 40; i++) begin @(negedge clk); if (pd) n++; end
      chk("R8 continues fast", n, 0);
      chk("R8 single wake pulse", wake_seen, 1);
      stop_run();

      // goal of zero behaves as one
      pat = 8'hFF; wake_seen = 0; wake_round = -1;
      start_run(2'd2, 1, 3, 0);
      for (int i = 0; i < 2000 && wake_seen == 0; i++) @(negedge clk);
      chk("R8 goal zero", wake_round, 1);
      stop_run();

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule